// File: doc/BRIEF.md
# Redundant Synchronizer Selection Controller

This block calibrates a bank of four identical two-stage synchronizers that all see the same asynchronous signal, and keeps the best one. Each synchronizer cell reports two samples of the captured value: one taken at a shortened resolution time and one taken a cycle later. After a single start pulse, the controller watches each candidate in turn for a programmable number of clock cycles. It counts the cycles in which the two samples disagree, and stores that count for the candidate.

When all four candidates have been measured, the controller picks the one with the fewest disagreements and registers its index as the output-multiplexer select. It then raises a done flag, keeps power enabled only for the chosen synchronizer, and drops the enable of its own measurement logic. The choice holds until reset, so calibration happens once, at chip setup.

Top module: `sync_sel_ctrl`

## Requirements
- R1: After reset, done_o is 0, busy_o is 0, sel_o is 0, all four bits of cand_pwr_en_o are 1 and meas_pwr_en_o is 1.
- R2: A start_i high while idle begins measurement. busy_o is 1 from the next cycle until done_o rises. Candidates 0, 1, 2 and 3 are measured in that order, each for exactly W cycles. W is window_i captured on the start cycle, and a value of 0 is treated as 1.
- R3: In a measurement cycle of candidate k, a failure is counted when cand_early_i[k] differs from cand_late_i[k]. The bits of the other candidates have no effect on any count.
- R4: Each failure count saturates at 2^CNT_W-1 (255 by default) and does not wrap.
- R5: The select value is the index of the candidate with the smallest failure count. When counts are equal, the lowest index wins.
- R6: done_o rises exactly 4*W+1 cycles after the start cycle. busy_o and done_o are never 1 together.
- R7: Once done_o is 1, done_o and sel_o stay constant until reset, and start_i is ignored.
- R8: While done_o is 1, cand_pwr_en_o is one-hot with the set bit at sel_o, and meas_pwr_en_o is 0. Before done, all enables are 1.
- R9: sync_o always equals cand_late_i[sel_o].
- R10: A start_i pulse during measurement has no effect on the sequence or the result.
- R11: Changes of window_i after the start cycle have no effect on the window length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Calibration start pulse |
| window_i | input | WIN_W | Measurement cycles per candidate |
| cand_early_i | input | NUM_CAND | Per-candidate sample at the shortened resolution time |
| cand_late_i | input | NUM_CAND | Per-candidate sample one cycle later |
| sync_o | output | 1 | Synchronized output of the chosen candidate |
| sel_o | output | SEL_W | Chosen candidate index |
| busy_o | output | 1 | Measurement in progress |
| done_o | output | 1 | Selection complete and latched |
| cand_pwr_en_o | output | NUM_CAND | Power enable per candidate |
| meas_pwr_en_o | output | 1 | Power enable of the measurement logic |

## Verification
Two events can coincide on a window's final cycle:
- a failure that must still be credited to the current candidate, and
- the hand-over that stores the count and clears the counter for the next candidate.

The bench provokes this by placing failures only at the tail of each window. It also drives disagreeing bits on the unmeasured candidates in every cycle. If a tail failure were lost, or credited to the next candidate, the resulting select value would differ from the one predicted by the bench.

A second collision is a failure arriving when a count is already at its ceiling. Windows of 300 cycles, with counts set so that wrapping and saturating predict different winners, judge this case.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MEAS = 2'd1,
    ST_PICK = 2'd2,
    ST_DONE = 2'd3
  } ssc_state_e;
endpackage

// File: rtl/ssc_fail_counter.sv
module ssc_fail_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             fail_i,
  output logic [CNT_W-1:0] sum_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             hit;

  // sum_o already includes this cycle's failure so the last sample is kept
  assign hit   = en_i && fail_i && (cnt_q != CNT_MAX);
  assign sum_o = cnt_q + CNT_W'(hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (en_i)   cnt_q <= sum_o;
  end
endmodule

// File: rtl/ssc_sequencer.sv
module ssc_sequencer
  import ssc_pkg::*;
#(
  parameter int NUM_CAND = 4,
  parameter int SEL_W    = 2,
  parameter int WIN_W    = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [WIN_W-1:0] window_i,
  output logic [SEL_W-1:0] cand_o,
  output logic             count_en_o,
  output logic             clr_o,
  output logic             store_o,
  output logic             pick_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam logic [SEL_W-1:0] LAST_CAND = SEL_W'(NUM_CAND - 1);

  ssc_state_e       state_q;
  logic [WIN_W-1:0] win_len_q;
  logic [WIN_W-1:0] win_cnt_q;
  logic [SEL_W-1:0] cand_q;
  logic             start_ok;
  logic             win_last;

  assign start_ok   = (state_q == ST_IDLE) && start_i;
  assign win_last   = (win_cnt_q == win_len_q - WIN_W'(1));
  assign count_en_o = (state_q == ST_MEAS);
  assign store_o    = (state_q == ST_MEAS) && win_last;
  assign clr_o      = start_ok || store_o;
  assign pick_o     = (state_q == ST_PICK);
  assign busy_o     = (state_q == ST_MEAS) || (state_q == ST_PICK);
  assign done_o     = (state_q == ST_DONE);
  assign cand_o     = cand_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      win_len_q <= WIN_W'(1);
      win_cnt_q <= '0;
      cand_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            // zero window is clamped so every candidate gets one sample
            win_len_q <= (window_i == '0) ? WIN_W'(1) : window_i;
            win_cnt_q <= '0;
            cand_q    <= '0;
            state_q   <= ST_MEAS;
          end
        end
        ST_MEAS: begin
          if (win_last) begin
            win_cnt_q <= '0;
            if (cand_q == LAST_CAND) state_q <= ST_PICK;
            else                     cand_q  <= cand_q + SEL_W'(1);
          end else begin
            win_cnt_q <= win_cnt_q + WIN_W'(1);
          end
        end
        ST_PICK: state_q <= ST_DONE;
        ST_DONE: state_q <= ST_DONE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ssc_min_picker.sv
module ssc_min_picker #(
  parameter int NUM_CAND = 4,
  parameter int CNT_W    = 8,
  parameter int SEL_W    = 2
) (
  input  logic [NUM_CAND-1:0][CNT_W-1:0] counts_i,
  output logic [SEL_W-1:0]               idx_o
);
  logic [CNT_W-1:0] best;

  // strict compare keeps the lower index on ties
  always_comb begin
    best  = counts_i[0];
    idx_o = '0;
    for (int i = 1; i < NUM_CAND; i++) begin
      if (counts_i[i] < best) begin
        best  = counts_i[i];
        idx_o = SEL_W'(i);
      end
    end
  end
endmodule

// File: rtl/sync_sel_ctrl.sv
module sync_sel_ctrl #(
  parameter int NUM_CAND = 4,
  parameter int CNT_W    = 8,
  parameter int WIN_W    = 10,
  localparam int SEL_W   = $clog2(NUM_CAND)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [WIN_W-1:0]    window_i,
  input  logic [NUM_CAND-1:0] cand_early_i,
  input  logic [NUM_CAND-1:0] cand_late_i,
  output logic                sync_o,
  output logic [SEL_W-1:0]    sel_o,
  output logic                busy_o,
  output logic                done_o,
  output logic [NUM_CAND-1:0] cand_pwr_en_o,
  output logic                meas_pwr_en_o
);
  logic [SEL_W-1:0]              cand;
  logic                          count_en, clr, store, pick, fail;
  logic [CNT_W-1:0]              sum;
  logic [NUM_CAND-1:0][CNT_W-1:0] bank;
  logic [SEL_W-1:0]              pick_idx;
  logic [SEL_W-1:0]              sel_q;

  ssc_sequencer #(
    .NUM_CAND(NUM_CAND), .SEL_W(SEL_W), .WIN_W(WIN_W)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .window_i  (window_i),
    .cand_o    (cand),
    .count_en_o(count_en),
    .clr_o     (clr),
    .store_o   (store),
    .pick_o    (pick),
    .busy_o    (busy_o),
    .done_o    (done_o)
  );

  assign fail = cand_early_i[cand] ^ cand_late_i[cand];

  ssc_fail_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .en_i  (count_en),
    .fail_i(fail),
    .sum_o (sum)
  );

  for (genvar g = 0; g < NUM_CAND; g++) begin : g_slot
    logic [CNT_W-1:0] slot_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            slot_q <= '0;
      else if (store && (cand == SEL_W'(g)))  slot_q <= sum;
    end
    assign bank[g]          = slot_q;
    assign cand_pwr_en_o[g] = !done_o || (sel_q == SEL_W'(g));
  end

  ssc_min_picker #(
    .NUM_CAND(NUM_CAND), .CNT_W(CNT_W), .SEL_W(SEL_W)
  ) u_pick (
    .counts_i(bank),
    .idx_o   (pick_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sel_q <= '0;
    else if (pick) sel_q <= pick_idx;
  end

  assign sel_o         = sel_q;
  assign sync_o        = cand_late_i[sel_q];
  assign meas_pwr_en_o = !done_o;
endmodule

// File: rtl/ssc_checker.sv
module ssc_checker #(
  parameter int NUM_CAND = 4,
  parameter int SEL_W    = 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                start_i,
  input logic [SEL_W-1:0]    sel_o,
  input logic                busy_o,
  input logic                done_o,
  input logic [NUM_CAND-1:0] cand_pwr_en_o,
  input logic                meas_pwr_en_o
);
  a_r7_sel_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o && $stable(sel_o));

  a_r8_power_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($countones(cand_pwr_en_o) == 1) && cand_pwr_en_o[sel_o] && !meas_pwr_en_o);

  a_r8_all_on_before: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> (&cand_pwr_en_o) && meas_pwr_en_o);

  a_r6_done_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(busy_o));

  a_r6_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));

  a_r10_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (busy_o || done_o));
endmodule

bind sync_sel_ctrl ssc_checker #(.NUM_CAND(NUM_CAND), .SEL_W(SEL_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .sel_o        (sel_o),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .cand_pwr_en_o(cand_pwr_en_o),
  .meas_pwr_en_o(meas_pwr_en_o)
);

// File: tb/sync_sel_ctrl_tb_top.sv
module sync_sel_ctrl_tb_top;
  localparam int NC      = 4;
  localparam int CW      = 8;
  localparam int WW      = 10;
  localparam int CNT_MAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [WW-1:0] window = '0;
  logic [NC-1:0] early = '0;
  logic [NC-1:0] late = '0;
  logic          sync_out;
  logic [1:0]    sel;
  logic          busy, done;
  logic [NC-1:0] cpwr;
  logic          mpwr;

  int n_cmp = 0;
  int n_bad = 0;
  int prm[NC];
  int tally[NC];

  always #5 clk = ~clk;

  sync_sel_ctrl #(.NUM_CAND(NC), .CNT_W(CW), .WIN_W(WW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .window_i(window),
    .cand_early_i(early), .cand_late_i(late), .sync_o(sync_out),
    .sel_o(sel), .busy_o(busy), .done_o(done),
    .cand_pwr_en_o(cpwr), .meas_pwr_en_o(mpwr)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_pick();
    int best = tally[0] > CNT_MAX ? CNT_MAX : tally[0];
    int idx = 0;
    for (int i = 1; i < NC; i++) begin
      int v = tally[i] > CNT_MAX ? CNT_MAX : tally[i];
      if (v < best) begin best = v; idx = i; end
    end
    return idx;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; start = 1'b0;
    @(negedge clk);
    chk("R1 done", int'(done), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 sel", int'(sel), 0);
    chk("R1 cand_pwr", int'(cpwr), 15);
    chk("R1 meas_pwr", int'(mpwr), 1);
    late = 4'b0001;
    #1 chk("R9 idle mux", int'(sync_out), 1);
    rst_n = 1'b1;
  endtask

  // mode 0: random rate %, mode 1: failures at window head, mode 2: at window tail
  task automatic run_calib(input int n, input int mode);
    int neff = (n == 0) ? 1 : n;
    int es;
    for (int k = 0; k < NC; k++) tally[k] = 0;
    @(negedge clk);
    start = 1'b1; window = WW'(n);
    @(negedge clk);
    start = 1'b0; window = WW'($urandom);
    chk("R2 busy after start", int'(busy), 1);
    for (int k = 0; k < NC; k++) begin
      for (int i = 0; i < neff; i++) begin
        logic f;
        logic [NC-1:0] e, noise;
        case (mode)
          0:       f = (($urandom % 100) < prm[k]);
          1:       f = (i < prm[k]);
          default: f = (i >= neff - prm[k]);
        endcase
        if (f) tally[k]++;
        e = NC'($urandom); noise = NC'($urandom);  // R3 noise on unmeasured candidates
        noise[k] = f;
        early = e; late = e ^ noise;
        start = (k == 1 && i == 0);  // R10 stray start mid-run
        if (i == 0 && k > 0) window = WW'($urandom);  // R11
        @(negedge clk);
        if (!(k == NC - 1 && i == neff - 1))
          chk("R2 busy during window", int'(busy), 1);
      end
    end
    start = 1'b0;
    chk("R6 done not yet", int'(done), 0);
    @(negedge clk);
    chk("R6 done at 4W+1", int'(done), 1);
    chk("R6 busy off", int'(busy), 0);
    es = exp_pick();
    chk("R5 selection", int'(sel), es);
    chk("R8 cand_pwr onehot", int'(cpwr), 1 << es);
    chk("R8 meas_pwr off", int'(mpwr), 0);
    for (int j = 0; j < 4; j++) begin
      late = NC'($urandom);
      #1 chk("R9 mux", int'(sync_out), int'(late[es]));
      @(negedge clk);
    end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk("R7 done held", int'(done), 1);
    chk("R7 sel held", int'(sel), es);
    chk("R7 no restart", int'(busy), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    // R2 zero window clamp
    do_reset();
    prm = '{1, 1, 0, 1}; run_calib(0, 1);
    // R5 tie at zero picks lowest
    do_reset();
    prm = '{0, 0, 0, 0}; run_calib(7, 1);
    // R3 tail failures on window boundaries
    do_reset();
    prm = '{3, 1, 2, 1}; run_calib(9, 2);
    do_reset();
    prm = '{4, 4, 4, 2}; run_calib(6, 2);
    // R4 saturation: wrapping would pick candidate 1
    do_reset();
    prm = '{300, 256, 260, 255}; run_calib(300, 1);
    do_reset();
    prm = '{300, 200, 280, 290}; run_calib(300, 1);
    // random rates
    for (int r = 0; r < 6; r++) begin
      do_reset();
      for (int k = 0; k < NC; k++) prm[k] = $urandom % 60;
      run_calib(1 + ($urandom % 40), 0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule